// File: doc/BRIEF.md
# Local Bus Chip-Select Cycle Controller

This block drives one external bus access on a single chip-select line each time the internal side raises a request. It holds its own 32-bit configuration word. The word sets how long chip select stays active, whether address and data share the bus in two tenures, whether an external acknowledge may end the wait early, and whether the line may run at all. The wait length is built from an 8-bit prescale and an 8-bit base count, combined in one of four ways.

In the single-tenure mode the address goes out on a dedicated address port, and data uses the shared bus. In the two-tenure mode the shared bus first carries the address for one clock while address-latch enable is high, and then switches to data while chip select is active. When chip select is released, a one-clock done pulse is raised and read data is captured from the bus on the same edge. An instance can be marked as the boot chip select. A boot instance takes its reset configuration from two strap pins and ignores the global enable.

Top module: `lbc_cs_ctrl`

## Requirements
- R1: Configuration word layout, with bit 0 as the LSB:
  - [7:0] base count.
  - [15:8] prescale.
  - [17:16] wait type: 00 uses the base count, 01 uses the prescale, 10 uses prescale plus base, and 11 uses prescale times base, saturated to 16 bits.
  - [18] two-tenure mode.
  - [19] acknowledge enable.
  - [20] line enable.
  - [31:21] are stored but unused.
- R2: Single-tenure mode: chip select rises on the clock after the request is sampled, and stays high for exactly N clocks, where N is the wait count. Address-latch enable stays low.
- R3: Two-tenure mode: address-latch enable is high for exactly one clock after the request, with the address on the shared bus and the bus output enable on. Chip select then rises on the next clock and stays high for N clocks. Chip select and address-latch enable are never high together.
- R4: A wait count of zero still gives one chip-select clock.
- R5: In two-tenure mode with acknowledge enable set, a low acknowledge sampled while chip select is high makes that clock the last chip-select clock.
- R6: The acknowledge input has no effect when acknowledge enable is 0 or when the mode is single-tenure.
- R7: An access starts only if the line enable bit is 1 and either the global enable is 1 or the instance is the boot chip select. A blocked request produces no chip select, no address-latch enable and no done. Configuration writes take effect while the line is disabled.
- R8: A boot instance resets to: line enabled, wait type 00, base count 4 if the wait strap is low or 48 if it is high, and two-tenure mode equal to the mode strap. A non-boot instance resets to all zeros, which means disabled.
- R9: done_o pulses for exactly one clock, on the first clock after chip select falls. rdata_o holds the shared-bus input value sampled at the edge where chip select fell.
- R10: On a write, the shared bus carries the write data with output enable on for every chip-select clock. On a read, output enable is off while chip select is high.
- R11: A request that arrives while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_wait_i | input | 1 | Boot wait strap (0: 4 clocks, 1: 48 clocks) |
| strap_mux_i | input | 1 | Boot mode strap (1: two-tenure) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write value |
| glb_en_i | input | 1 | Global enable |
| req_i | input | 1 | Access request pulse |
| we_i | input | 1 | 1 = write access |
| addr_i | input | AW | Access address |
| wdata_i | input | DW | Write data |
| ack_ni | input | 1 | Active-low external acknowledge |
| cs_o | output | 1 | Chip select, active high |
| ale_o | output | 1 | Address-latch enable |
| addr_o | output | AW | Address held for the access |
| ad_o | output | DW | Shared bus output value |
| ad_oe_o | output | 1 | Shared bus output enable |
| ad_i | input | DW | Shared bus input value |
| done_o | output | 1 | One-clock end-of-access pulse |
| rdata_o | output | DW | Captured read data |

## Verification
Take the request to be sampled at edge k. In single-tenure mode chip select is high from edge k through N edges, and done and rdata appear after edge k+N. In two-tenure mode address-latch enable follows edge k, chip select follows edges k+1 through k+N, and done follows edge k+N+1. The bench drives inputs and samples outputs on falling edges, numbering each sample from the request. It checks the index of the first chip-select sample, the run length, the single done at first-chip-select index plus N, and the captured data against these formulas. The bench lowers acknowledge at the falling edge where it sees chip-select clock j, so the run is expected to be exactly j long.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  localparam int FLD_W = 8;
  localparam int CFG_W = 32;

  typedef enum logic [1:0] {
    WT_BASE = 2'b00,
    WT_PRE  = 2'b01,
    WT_SUM  = 2'b10,
    WT_MUL  = 2'b11
  } wtype_e;

  typedef struct packed {
    logic [10:0]      rsvd;
    logic             enable;
    logic             ack_en;
    logic             mux;
    wtype_e           wtype;
    logic [FLD_W-1:0] pre;
    logic [FLD_W-1:0] base;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ALE  = 2'b01,
    ST_DATA = 2'b10
  } st_e;
endpackage

// File: rtl/lbc_cfg_reg.sv
module lbc_cfg_reg
  import lbc_pkg::*;
#(
  parameter bit IS_BOOT      = 1'b1,
  parameter int BOOT_WAIT_LO = 4,
  parameter int BOOT_WAIT_HI = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_wait_i,
  input  logic             strap_mux_i,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);
  cfg_t rst_val;

  generate
    if (IS_BOOT) begin : g_boot
      always_comb begin
        rst_val        = '0;
        rst_val.base   = strap_wait_i ? FLD_W'(BOOT_WAIT_HI) : FLD_W'(BOOT_WAIT_LO);
        rst_val.wtype  = WT_BASE;
        rst_val.mux    = strap_mux_i;
        rst_val.enable = 1'b1;
      end
    end else begin : g_plain
      assign rst_val = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= rst_val;
    else if (we_i) cfg_o <= cfg_t'(wdata_i);
  end
endmodule

// File: rtl/lbc_wait_calc.sv
module lbc_wait_calc
  import lbc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  wtype_e           wtype_i,
  input  logic [FLD_W-1:0] pre_i,
  input  logic [FLD_W-1:0] base_i,
  output logic [CNT_W-1:0] wait_o
);
  localparam int RAW_W = 2 * FLD_W + 1;

  logic [RAW_W-1:0] raw;

  always_comb begin
    unique case (wtype_i)
      WT_BASE: raw = RAW_W'(base_i);
      WT_PRE:  raw = RAW_W'(pre_i);
      WT_SUM:  raw = RAW_W'(pre_i) + RAW_W'(base_i);
      default: raw = RAW_W'(pre_i) * RAW_W'(base_i);
    endcase
  end

  generate
    if (CNT_W >= RAW_W) begin : g_wide
      assign wait_o = CNT_W'(raw);
    end else begin : g_sat
      assign wait_o = (|raw[RAW_W-1:CNT_W]) ? '1 : raw[CNT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/lbc_cycle_fsm.sv
module lbc_cycle_fsm
  import lbc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             go_i,
  input  logic [CNT_W-1:0] wait_i,
  input  logic             mux_i,
  input  logic             ack_en_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             ack_ni,
  input  logic [DW-1:0]    ad_i,
  output logic             cs_o,
  output logic             ale_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o,
  output logic             busy_o
);
  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    wdata_q;
  logic             wr_q;
  logic             ack_q;
  logic [CNT_W-1:0] last_cnt;
  logic             end_now;

  // zero wait still yields one data clock
  assign last_cnt = (wait_i == '0) ? '0 : wait_i - CNT_W'(1);
  assign end_now  = (cnt_q == '0) || (ack_q && !ack_ni);
  assign busy_o   = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      ack_q   <= 1'b0;
      cs_o    <= 1'b0;
      ale_o   <= 1'b0;
      addr_o  <= '0;
      ad_o    <= '0;
      ad_oe_o <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_i && go_i) begin
            wr_q    <= we_i;
            wdata_q <= wdata_i;
            addr_o  <= addr_i;
            ack_q   <= mux_i && ack_en_i;
            cnt_q   <= last_cnt;
            if (mux_i) begin
              st_q    <= ST_ALE;
              ale_o   <= 1'b1;
              ad_o    <= DW'(addr_i);
              ad_oe_o <= 1'b1;
            end else begin
              st_q    <= ST_DATA;
              cs_o    <= 1'b1;
              ad_o    <= wdata_i;
              ad_oe_o <= we_i;
            end
          end
        end
        ST_ALE: begin
          st_q    <= ST_DATA;
          ale_o   <= 1'b0;
          cs_o    <= 1'b1;
          ad_o    <= wdata_q;
          ad_oe_o <= wr_q;
        end
        default: begin
          if (end_now) begin
            st_q    <= ST_IDLE;
            cs_o    <= 1'b0;
            ad_oe_o <= 1'b0;
            done_o  <= 1'b1;
            rdata_o <= ad_i;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lbc_cs_ctrl.sv
module lbc_cs_ctrl
  import lbc_pkg::*;
#(
  parameter int AW           = 32,
  parameter int DW           = 32,
  parameter int CNT_W        = 16,
  parameter bit IS_BOOT      = 1'b1,
  parameter int BOOT_WAIT_LO = 4,
  parameter int BOOT_WAIT_HI = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_wait_i,
  input  logic             strap_mux_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             glb_en_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             ack_ni,
  output logic             cs_o,
  output logic             ale_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  input  logic [DW-1:0]    ad_i,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o
);
  cfg_t             cfg;
  logic [CNT_W-1:0] wait_cnt;
  logic             acc_ok;
  logic             busy;

  lbc_cfg_reg #(
    .IS_BOOT     (IS_BOOT),
    .BOOT_WAIT_LO(BOOT_WAIT_LO),
    .BOOT_WAIT_HI(BOOT_WAIT_HI)
  ) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strap_wait_i(strap_wait_i),
    .strap_mux_i (strap_mux_i),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .cfg_o       (cfg)
  );

  lbc_wait_calc #(.CNT_W(CNT_W)) u_wait (
    .wtype_i(cfg.wtype),
    .pre_i  (cfg.pre),
    .base_i (cfg.base),
    .wait_o (wait_cnt)
  );

  // boot line ignores the global enable
  assign acc_ok = cfg.enable && (IS_BOOT || glb_en_i);

  lbc_cycle_fsm #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .go_i    (acc_ok),
    .wait_i  (wait_cnt),
    .mux_i   (cfg.mux),
    .ack_en_i(cfg.ack_en),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ack_ni  (ack_ni),
    .ad_i    (ad_i),
    .cs_o    (cs_o),
    .ale_o   (ale_o),
    .addr_o  (addr_o),
    .ad_o    (ad_o),
    .ad_oe_o (ad_oe_o),
    .done_o  (done_o),
    .rdata_o (rdata_o),
    .busy_o  (busy)
  );
endmodule

// File: rtl/lbc_cs_ctrl_chk.sv
module lbc_cs_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic go_i,
  input logic busy_i,
  input logic cs_i,
  input logic ale_i,
  input logic done_i
);
  a_r3_ale_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_i |=> !ale_i);
  a_r3_ale_then_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_i |=> cs_i);
  a_r3_ale_cs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_i && cs_i));
  a_r9_done_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_i) |-> done_i);
  a_r9_done_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  a_r7_blocked_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_i && !go_i) |=> (!cs_i && !ale_i));
  a_r11_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cs_i && !done_i) |=> (cs_i || done_i));
endmodule

bind lbc_cs_ctrl lbc_cs_ctrl_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .req_i (req_i),
  .go_i  (acc_ok),
  .busy_i(busy),
  .cs_i  (cs_o),
  .ale_i (ale_o),
  .done_i(done_o)
);

// File: tb/lbc_cs_ctrl_tb_top.sv
module lbc_cs_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_wait = 1'b0, strap_mux = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        glb_en = 1'b1;
  logic        req = 1'b0, sel = 1'b0, we = 1'b0, ack_n = 1'b1;
  logic [31:0] addr = '0, wdata = '0, ad_in = '0;
  int checks = 0, errors = 0;

  logic        cs_a, ale_a, oe_a, done_a, cs_b, ale_b, oe_b, done_b;
  logic [31:0] addro_a, ad_a, rd_a, addro_b, ad_b, rd_b;
  logic        cs_w, ale_w, oe_w, done_w;
  logic [31:0] ad_w, rd_w;

  always #4 clk = ~clk;

  lbc_cs_ctrl #(.IS_BOOT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strap_wait_i(strap_wait), .strap_mux_i(strap_mux),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .glb_en_i(glb_en),
    .req_i(req && !sel), .we_i(we), .addr_i(addr), .wdata_i(wdata), .ack_ni(ack_n),
    .cs_o(cs_a), .ale_o(ale_a), .addr_o(addro_a), .ad_o(ad_a), .ad_oe_o(oe_a),
    .ad_i(ad_in), .done_o(done_a), .rdata_o(rd_a));

  lbc_cs_ctrl #(.IS_BOOT(1'b0)) dut_nb_i (
    .clk_i(clk), .rst_ni(rst_n), .strap_wait_i(strap_wait), .strap_mux_i(strap_mux),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .glb_en_i(glb_en),
    .req_i(req && sel), .we_i(we), .addr_i(addr), .wdata_i(wdata), .ack_ni(ack_n),
    .cs_o(cs_b), .ale_o(ale_b), .addr_o(addro_b), .ad_o(ad_b), .ad_oe_o(oe_b),
    .ad_i(ad_in), .done_o(done_b), .rdata_o(rd_b));

  assign cs_w   = sel ? cs_b   : cs_a;
  assign ale_w  = sel ? ale_b  : ale_a;
  assign oe_w   = sel ? oe_b   : oe_a;
  assign done_w = sel ? done_b : done_a;
  assign ad_w   = sel ? ad_b   : ad_a;
  assign rd_w   = sel ? rd_b   : rd_a;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(bit en, bit ack, bit mux, int wt, int pre, int base);
    return {11'b0, en, ack, mux, wt[1:0], pre[7:0], base[7:0]};
  endfunction

  function automatic int exp_wait(int wt, int pre, int base);
    int w;
    case (wt)
      0: w = base;
      1: w = pre;
      2: w = pre + base;
      default: w = pre * base;
    endcase
    if (w > 65535) w = 65535;
    return (w == 0) ? 1 : w;
  endfunction

  task automatic do_reset(bit sw, bit sm);
    @(negedge clk);
    rst_n = 1'b0; strap_wait = sw; strap_mux = sm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_cfg(logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one access; indices count falling-edge samples after the request edge
  task automatic run(string rq, bit s, int n, bit mux, bit wr, int ack_at, bit dup);
    int cs_cnt = 0, first_cs = 0, ale_cnt = 0, ale_idx = 0, done_cnt = 0, done_idx = 0;
    int bad = 0;
    logic [31:0] rd = '0;
    @(negedge clk);
    sel = s; req = 1'b1; we = wr;
    addr = $urandom; wdata = $urandom; ad_in = $urandom;
    @(negedge clk);
    req = 1'b0;
    for (int i = 1; i <= n + 8; i++) begin
      if (ale_w) begin
        ale_cnt++; ale_idx = i;
        if (!oe_w || ad_w != addr) bad++;
      end
      if (cs_w) begin
        cs_cnt++;
        if (first_cs == 0) first_cs = i;
        if (wr && (!oe_w || ad_w != wdata)) bad++;
        if (!wr && oe_w) bad++;
      end
      if (done_w) begin
        done_cnt++; done_idx = i; rd = rd_w;
      end
      if (ack_at > 0 && cs_w && cs_cnt == ack_at) ack_n = 1'b0;
      if (dup && i == 2) req = 1'b1;
      if (dup && i == 3) req = 1'b0;
      @(negedge clk);
    end
    ack_n = 1'b1; req = 1'b0;
    chk(cs_cnt == n, rq, "cs length", cs_cnt, n);
    chk(first_cs == (mux ? 2 : 1), rq, "cs start index", first_cs, mux ? 2 : 1);
    chk(ale_cnt == (mux ? 1 : 0), rq, "ale clocks", ale_cnt, mux ? 1 : 0);
    if (mux) chk(ale_idx == 1, rq, "ale index", ale_idx, 1);
    chk(done_cnt == 1, rq, "done pulses", done_cnt, 1);
    chk(done_idx == first_cs + n, rq, "done index", done_idx, first_cs + n);
    chk(bad == 0, rq, "bus drive errors", bad, 0);
    if (!wr) chk(rd == ad_in, rq, "read data", rd, ad_in);
  endtask

  task automatic run_blocked(string rq, bit s);
    int hits = 0;
    @(negedge clk);
    sel = s; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (cs_w || ale_w || done_w) hits++;
      @(negedge clk);
    end
    chk(hits == 0, rq, "blocked activity", hits, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b0, 1'b0);
    // reset state
    chk(!cs_a && !ale_a && !done_a && !oe_a, "R8", "idle outputs", cs_a, 0);
    // R8 boot defaults: 4 clocks, single tenure; non-boot disabled
    run("R8", 1'b0, 4, 1'b0, 1'b0, 0, 1'b0);
    run_blocked("R8", 1'b1);
    do_reset(1'b1, 1'b1);
    run("R8", 1'b0, 48, 1'b1, 1'b0, 0, 1'b0);

    // R1 R2 R3 R4 R9 R10 sweep
    for (int wt = 0; wt < 4; wt++)
      for (int p = 0; p < 4; p += 1)
        for (int b = 0; b < 6; b += 2) begin
          bit mx = ((p + b + wt) % 2) == 1;
          bit wr = (b % 4) == 2;
          wr_cfg(mk_cfg(1, 0, mx, wt, p, b + (p % 2)));
          run("R1", 1'b0, exp_wait(wt, p, b + (p % 2)), mx, wr, 0, 1'b0);
        end
    // R4 zero wait
    wr_cfg(mk_cfg(1, 0, 1, 0, 7, 0));
    run("R4", 1'b0, 1, 1'b1, 1'b1, 0, 1'b0);
    // R1 large product
    wr_cfg(mk_cfg(1, 0, 0, 3, 20, 30));
    run("R1", 1'b0, 600, 1'b0, 1'b0, 0, 1'b0);

    // R5 early acknowledge
    wr_cfg(mk_cfg(1, 1, 1, 0, 0, 10));
    run("R5", 1'b0, 3, 1'b1, 1'b0, 3, 1'b0);
    run("R5", 1'b0, 1, 1'b1, 1'b1, 1, 1'b0);
    // R6 acknowledge ignored
    wr_cfg(mk_cfg(1, 0, 1, 0, 0, 10));
    run("R6", 1'b0, 10, 1'b1, 1'b0, 3, 1'b0);
    wr_cfg(mk_cfg(1, 1, 0, 0, 0, 10));
    run("R6", 1'b0, 10, 1'b0, 1'b0, 3, 1'b0);

    // R11 second request while busy
    wr_cfg(mk_cfg(1, 0, 0, 0, 0, 6));
    run("R11", 1'b0, 6, 1'b0, 1'b0, 0, 1'b1);

    // R7 enables
    wr_cfg(mk_cfg(0, 0, 0, 0, 0, 5));
    run_blocked("R7", 1'b0);
    run_blocked("R7", 1'b1);
    wr_cfg(mk_cfg(1, 0, 0, 2, 1, 2));
    run("R7", 1'b0, 3, 1'b0, 1'b0, 0, 1'b0);
    glb_en = 1'b0;
    run_blocked("R7", 1'b1);
    run("R7", 1'b0, 3, 1'b0, 1'b1, 0, 1'b0);
    glb_en = 1'b1;
    run("R7", 1'b1, 3, 1'b0, 1'b0, 0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule